// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Reporting

This block turns an asynchronous serial line into parallel characters. It uses an oversampling tick supplied from outside, at sixteen ticks per bit by default. The line passes through a two-stage synchronizer. While reception is enabled, a low level seen on a tick starts a candidate start bit. That start bit is confirmed by a second sample taken halfway through the bit. Each later bit is sampled once, a full bit period after the one before it, so that every sample lands near the centre of its bit.

The frame format is set by static inputs: 7, 8 or 9 data bits sent least significant bit first, optional parity of either sense, and one or two stop bits. A finished character is copied into a receive buffer. The copy sets a buffer-full flag and raises a one-cycle interrupt request. The host reads the buffer by pulsing a read strobe, which clears the full flag.

Overrun, framing and parity faults each set their own sticky flag. A summary flag shows whether any of them is set. All error flags clear when the host pulses the clear input or turns reception off.

Top module: `serial_rx_core`

## Requirements
- R1: With `rx_en` high, a low synchronized line on a tick starts a character; the line is sampled again on the 8th following tick, and a low value there starts data reception.
- R2: If the line is high at that 8th-tick start check, the receiver drops back to idle without producing a character or an interrupt.
- R3: The `char_len` input selects the data length: 0 gives 7 bits, 1 or 3 gives 8 bits, and 2 gives 9 bits. Data arrives least significant bit first and lands in `rx_data[0]` upward, and buffer bits above the selected length read 0.
- R4: When `par_en` is 1, a parity bit follows the data. `err_parity` is set when the number of ones across the data and parity bits is odd while `par_odd`=0, or even while `par_odd`=1. When `par_en` is 0, no parity bit is expected.
- R5: `two_stop` set to 0 expects one stop bit and set to 1 expects two. `err_frame` is set if any expected stop bit is sampled at 0.
- R6: After reset, the buffer, the full flag, the interrupt and all error flags are 0. Each accepted character raises `rx_irq` for exactly one cycle and sets `rx_full` in that same cycle.
- R7: A one-cycle `rd_strobe` pulse clears `rx_full` on the next cycle, unless a new character is accepted in that same cycle.
- R8: `err_overrun` is set when the bit just before the final stop bit of a character is sampled while `rx_full` is 1 and no read strobe arrives in that cycle. That bit is the last data bit, or the parity bit, or the first of two stop bits.
- R9: A character that raised an overrun is not written into the buffer and raises no interrupt. The buffer contents change only in a cycle where `rx_irq` is 1.
- R10: `err_any` is 1 exactly while any of the overrun, framing or parity flags is set. These flags stay set until `clr_err` is pulsed or `rx_en` is 0, and either of those clears all of them on the next cycle.
- R11: While `rx_en` is 0, line activity produces no character, no interrupt and no change to `rx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low forces idle and clears error flags |
| tick16 | input | 1 | Oversampling tick, OSR ticks per bit |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| char_len | input | 2 | Data length select (0: 7, 1/3: 8, 2: 9 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 expects two stop bits |
| rd_strobe | input | 1 | Host read of the buffer, clears the full flag |
| clr_err | input | 1 | Clears all error flags |
| rx_data | output | MAXBITS | Receive buffer |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | One-cycle receive-complete request |
| err_overrun | output | 1 | Sticky overrun flag |
| err_frame | output | 1 | Sticky framing flag |
| err_parity | output | 1 | Sticky parity flag |
| err_any | output | 1 | OR of the three error flags |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, a 9-bit buffer and two synchronizer stages. The bench supplies one tick every third clock, so ticks are not continuous. This exercises the counters' gating and puts the synchronizer delay at a random phase inside each tick. With a 9-bit buffer, every length setting can be reached, so 7-bit masking, 9-bit characters, both parity senses and both stop-bit counts are all covered. The 2-stage synchronizer keeps the first sample after a line edge late enough that a shortened start pulse and a bad final stop bit both end in a rejected false start rather than a spurious character.

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int OSR     = 16,
  parameter int MAXBITS = 9,
  parameter int SYNC    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               tick16,
  input  logic               rx_line,
  input  logic [1:0]         char_len,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               two_stop,
  input  logic               rd_strobe,
  input  logic               clr_err,
  output logic [MAXBITS-1:0] rx_data,
  output logic               rx_full,
  output logic               rx_irq,
  output logic               err_overrun,
  output logic               err_frame,
  output logic               err_parity,
  output logic               err_any
);

  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(MAXBITS + 1);
  localparam logic [TW-1:0] HALF = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] FULL = TW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t               st;
  logic [SYNC-1:0]   sync_q;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [MAXBITS-1:0] sh;
  logic              par_bit, stop_idx, fr_pend, ov_pend;

  logic              rx_s, samp, last_data, final_stop, prelast, done, par_bad;
  logic [BW-1:0]     nbits;

  assign rx_s = sync_q[SYNC-1];

  assign nbits = (char_len == 2'd0) ? BW'(7) :
                 (char_len == 2'd2) ? BW'(9) : BW'(8);

  assign samp = tick16 &&
                ((st == S_START && tcnt == HALF) ||
                 ((st == S_DATA || st == S_PAR || st == S_STOP) && tcnt == FULL));

  assign last_data  = (bidx == nbits - 1'b1);
  assign final_stop = (st == S_STOP) && (!two_stop || stop_idx);
  assign prelast    = (st == S_DATA && last_data && !par_en && !two_stop) ||
                      (st == S_PAR && !two_stop) ||
                      (st == S_STOP && two_stop && !stop_idx);
  assign done       = samp && final_stop;
  assign par_bad    = par_en && ((^sh ^ par_bit) != par_odd);
  assign err_any    = err_overrun | err_frame | err_parity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rx_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      sh       <= '0;
      par_bit  <= 1'b0;
      stop_idx <= 1'b0;
      fr_pend  <= 1'b0;
      ov_pend  <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE;
    end else if (tick16 && st != S_IDLE) begin
      if (samp) begin
        tcnt <= '0;
        if (prelast && rx_full && !rd_strobe) ov_pend <= 1'b1;
        case (st)
          S_START: st <= rx_s ? S_IDLE : S_DATA;
          S_DATA: begin
            sh[bidx] <= rx_s;
            bidx     <= bidx + 1'b1;
            if (last_data) st <= par_en ? S_PAR : S_STOP;
          end
          S_PAR: begin
            par_bit <= rx_s;
            st      <= S_STOP;
          end
          S_STOP: begin
            if (!rx_s) fr_pend <= 1'b1;
            if (final_stop) st <= S_IDLE;
            else            stop_idx <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end else if (tick16 && !rx_s) begin
      st       <= S_START;
      tcnt     <= '0;
      bidx     <= '0;
      sh       <= '0;
      par_bit  <= 1'b0;
      stop_idx <= 1'b0;
      fr_pend  <= 1'b0;
      ov_pend  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_irq  <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (rx_en && done && !ov_pend) begin
        rx_data <= sh;
        rx_full <= 1'b1;
        rx_irq  <= 1'b1;
      end else if (rd_strobe) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_overrun <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
    end else if (!rx_en || clr_err) begin
      err_overrun <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
    end else begin
      if (samp && prelast && rx_full && !rd_strobe) err_overrun <= 1'b1;
      if (done && (fr_pend || !rx_s))               err_frame   <= 1'b1;
      if (done && par_bad)                          err_parity  <= 1'b1;
    end
  end

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int MAXBITS = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_en,
  input logic               rd_strobe,
  input logic               clr_err,
  input logic [MAXBITS-1:0] rx_data,
  input logic               rx_full,
  input logic               rx_irq,
  input logic               err_overrun,
  input logic               err_any
);

  assert_irq_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (!rx_full || rx_irq));

  assert_buffer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq |-> $stable(rx_data));

  assert_ovr_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_full));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && rx_en && !clr_err) |=> err_any);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || clr_err) |=> !err_any);

endmodule

bind serial_rx_core serial_rx_core_chk #(.MAXBITS(MAXBITS)) chk_i (.*);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] char_len = 2'd1;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       rd_strobe = 1'b0, clr_err = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic       tick16;
  logic [8:0] rx_data;
  logic       rx_full, rx_irq, err_overrun, err_frame, err_parity, err_any;

  int n_chk = 0, n_bad = 0, irq_cnt = 0, irq_exp = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd0);
  always @(negedge clk) if (rx_irq) irq_cnt <= irq_cnt + 1;

  serial_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick16(tick16), .rx_line(rx_line),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .rd_strobe(rd_strobe), .clr_err(clr_err), .rx_data(rx_data), .rx_full(rx_full),
    .rx_irq(rx_irq), .err_overrun(err_overrun), .err_frame(err_frame),
    .err_parity(err_parity), .err_any(err_any)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int len_of(logic [1:0] cl);
    return (cl == 2'd0) ? 7 : (cl == 2'd2) ? 9 : 8;
  endfunction

  function automatic logic [8:0] masked(logic [8:0] d, int len);
    return d & 9'((1 << len) - 1);
  endfunction

  function automatic logic par_of(logic [8:0] d, int len, logic odd);
    return (^masked(d, len)) ^ odd;
  endfunction

  task automatic hold_bit(logic b);
    rx_line = b;
    repeat (48) @(negedge clk);
  endtask

  task automatic send(logic [8:0] d, logic bad_par, logic [1:0] bad_stop);
    int len = len_of(char_len);
    hold_bit(1'b0);
    for (int i = 0; i < len; i++) hold_bit(d[i]);
    if (par_en) hold_bit(par_of(d, len, par_odd) ^ bad_par);
    hold_bit(!bad_stop[0]);
    if (two_stop) hold_bit(!bad_stop[1]);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [8:0] d;
    logic       bp;
    logic [1:0] bs;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset full", rx_full, 0);
    chk("R6 reset irq", rx_irq, 0);
    chk("R6 reset err", err_any, 0);
    chk("R6 reset data", rx_data, 0);

    rx_en = 1'b1;
    repeat (10) @(negedge clk);
    send(9'h0A5, 0, 0); irq_exp++;
    chk("R1 data 8N1", rx_data, 9'h0A5);
    chk("R6 irq count", irq_cnt, irq_exp);
    chk("R6 full set", rx_full, 1);
    chk("R5 no frame err", err_any, 0);
    pulse_rd();
    chk("R7 read clears full", rx_full, 0);

    rx_line = 1'b0; repeat (9) @(negedge clk);
    repeat (3) hold_bit(1'b1);
    chk("R2 glitch no irq", irq_cnt, irq_exp);
    chk("R2 glitch no full", rx_full, 0);
    send(9'h03C, 0, 0); irq_exp++;
    chk("R2 after glitch data", rx_data, 9'h03C);

    send(9'h055, 0, 0);
    chk("R8 overrun set", err_overrun, 1);
    chk("R10 summary set", err_any, 1);
    chk("R9 no irq on overrun", irq_cnt, irq_exp);
    chk("R9 buffer kept", rx_data, 9'h03C);
    pulse_clr();
    chk("R10 clear", err_any, 0);

    fork
      send(9'h0C3, 0, 0);
      begin repeat (30) @(negedge clk); pulse_rd(); end
    join
    irq_exp++;
    chk("R8 early read no overrun", err_overrun, 0);
    chk("R8 early read data", rx_data, 9'h0C3);
    chk("R8 early read irq", irq_cnt, irq_exp);
    pulse_rd();

    two_stop = 1'b1;
    send(9'h011, 0, 2'b01); irq_exp++;
    chk("R5 bad first stop", err_frame, 1);
    chk("R5 data kept", rx_data, 9'h011);
    pulse_rd();
    rx_en = 1'b0; @(negedge clk); @(negedge clk);
    chk("R10 disable clears", err_any, 0);
    send(9'h000, 0, 0);
    chk("R11 disabled no irq", irq_cnt, irq_exp);
    chk("R11 disabled no full", rx_full, 0);
    rx_en = 1'b1; two_stop = 1'b0;
    repeat (10) @(negedge clk);

    char_len = 2'd0; par_en = 1'b1; par_odd = 1'b1;
    send(9'h1FF, 0, 0); irq_exp++;
    chk("R3 7-bit mask", rx_data, 9'h07F);
    chk("R4 odd parity ok", err_parity, 0);
    pulse_rd();
    char_len = 2'd2; par_odd = 1'b0;
    send(9'h155, 1, 0); irq_exp++;
    chk("R3 9-bit data", rx_data, 9'h155);
    chk("R4 even parity err", err_parity, 1);
    pulse_rd(); pulse_clr();

    for (int k = 0; k < 40; k++) begin
      char_len = 2'($urandom_range(0, 3));
      par_en   = 1'($urandom);
      par_odd  = 1'($urandom);
      two_stop = 1'($urandom);
      d  = 9'($urandom);
      bp = ($urandom_range(0, 5) == 0);
      bs = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      if (!two_stop) bs[1] = 1'b0;
      send(d, bp, bs); irq_exp++;
      chk("R3 random data", rx_data, masked(d, len_of(char_len)));
      chk("R4 random parity", err_parity, par_en & bp);
      chk("R5 random frame", err_frame, |bs);
      chk("R6 random irq", irq_cnt, irq_exp);
      pulse_rd(); pulse_clr();
    end
    finish_run();
  end

endmodule